// File: doc/BRIEF.md
# Multi-Level 2-D Reversible Wavelet Transform Engine

This block takes one image tile and turns it into a multi-level two-dimensional wavelet decomposition using the reversible integer 5/3 lifting filter. Samples arrive in raster order over a valid/ready stream and go into an on-chip tile memory. The block then runs the transform in place, one line at a time. Each level does a horizontal pass over every row of its region, then a vertical pass over every column. After each one-dimensional pass the low-pass results sit in the lower indices and the high-pass results follow them. Each later level works only on the low-low quadrant that the previous level left behind. A downstream stage reads the finished coefficients through a synchronous read port.

A start pulse latches the tile width, tile height, level count and mode, and opens the input stream. While samples are loading, `in_ready` is high. A sample moves on each rising edge where `in_valid` and `in_ready` are both high. The source may drop `in_valid` at any time. It must hold `in_data` steady while `in_valid` is high and no transfer has taken place. Outside the load phase `in_ready` is low and nothing is taken. When the last level finishes, `done` pulses for one cycle. A bypass mode stores the samples unchanged. The tile edge is a parameter (`MAX_DIM`, a power of two). The project is meant for tiles up to 128 by 128, and it defaults to 16 to keep simulation fast.

Top module: `dwt2d_engine`

## Requirements
- R1: After reset, `busy`, `done` and `in_ready` are all low.
- R2: A start in idle latches the configuration and raises `in_ready` on the next cycle. `in_ready` then stays high until width×height samples have transferred. A transfer takes place only on an edge where `in_valid` and `in_ready` are both high. The sample taken at raster position n is stored at x = n mod width, y = n div width. Samples offered while `in_ready` is low are dropped.
- R3: A start that arrives while `busy` is high has no effect. The running transform keeps its configuration, and no new load phase opens after `done`.
- R4: `done` is high for exactly one cycle. `busy` is high from the cycle after an accepted start through the `done` cycle, and low on the cycle after `done`.
- R5: When `cfg_mode` is 1 (bypass), or the level count is 0, the tile memory holds the input samples sign-extended to COEF_W bits, and `done` follows the load.
- R6: When `cfg_mode` is 0, each one-dimensional pass first lifts the odd samples: odd −= floor((left even + right even)/2). It then lifts the even samples: even += floor((left odd + right odd + 2)/4). Every step uses integer arithmetic.
- R7: Missing neighbours at a line end come from whole-sample symmetric extension, so x[−1]=x[1] and x[n]=x[n−2]. A line of length 1 is left unchanged.
- R8: Within each level, every row is transformed before any column. After each pass, output position k < ceil(n/2) holds lifted sample 2k, and position k ≥ ceil(n/2) holds lifted sample 2(k−ceil(n/2))+1.
- R9: Level k (k ≥ 1) covers the top-left ceil(W/2^(k−1)) × ceil(H/2^(k−1)) samples. Odd widths and heights are handled exactly.
- R10: A `cfg_levels` value above 5 runs 5 levels.
- R11: `rd_data` gives the coefficient at (`rd_x`, `rd_y`) one clock after the address is presented, as a two's-complement COEF_W value.
- R12: Applying inverse 5/3 lifting to the reversible output, in reverse level and pass order, restores the input tile exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a tile; acted on only while idle |
| cfg_width | input | DW+1 | Tile width, 1 to MAX_DIM |
| cfg_height | input | DW+1 | Tile height, 1 to MAX_DIM |
| cfg_levels | input | LVL_W | Decomposition levels, 0 to 5 (larger values clamp to 5) |
| cfg_mode | input | 1 | 0 = reversible 5/3, 1 = bypass |
| busy | output | 1 | Tile in progress |
| done | output | 1 | One-cycle completion pulse |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can take a sample |
| in_data | input | IN_W | Signed input sample |
| rd_x | input | DW | Read column |
| rd_y | input | DW | Read row |
| rd_data | output | COEF_W | Coefficient read one cycle after the address |

## Verification
The bench walks a table of tile shapes and checks the results against a behavioural lifting model. The table covers odd widths and heights, single-row and single-column tiles, 2×2 tiles, extreme alternating samples that push coefficient growth, level counts that shrink the region to one sample, and a level value above the limit. If mirroring at the edges were wrong, or odd-length halves were split in the wrong place, the coefficients in the last row or column of a region would differ from the model. An inverse lifting pass over the read-back data would then fail to give back the input. Directed tests offer samples before start, insert gaps in `in_valid`, and pulse start in the middle of a transform. A design that took samples while not ready, lost its place during a gap, or restarted on a busy start would store shifted data or reopen the input after `done`.

// File: rtl/dwt53_pkg.sv
package dwt53_pkg;

  // operation applied to the line buffer in a given cycle
  typedef enum logic [1:0] {
    LOP_HOLD,
    LOP_FILL,
    LOP_PRED,
    LOP_UPD
  } lift_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_FETCH,
    ST_PRED,
    ST_UPD,
    ST_STORE,
    ST_NEXT,
    ST_DONE
  } eng_state_e;

endpackage

// File: rtl/dwt2d_tile_mem.sv
module dwt2d_tile_mem #(
  parameter int AW = 8,
  parameter int CW = 23,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [CW-1:0] wdata,
  input  logic [AW-1:0] eng_addr,
  output logic [CW-1:0] eng_data,
  input  logic [AW-1:0] rd_addr,
  output logic [CW-1:0] rd_data
);

  logic [CW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  // engine side: combinational fetch of the current line element
  assign eng_data = mem_q[eng_addr];

  // reader side: registered, one cycle latency
  always_ff @(posedge clk) begin
    rd_data <= mem_q[rd_addr];
  end

endmodule

// File: rtl/dwt2d_line_unit.sv
module dwt2d_line_unit
  import dwt53_pkg::*;
#(
  parameter int MAX_DIM = 16,
  parameter int CW = 23,
  localparam int DW = $clog2(MAX_DIM)
) (
  input  logic          clk,
  input  lift_op_e      op,
  input  logic [DW-1:0] idx,
  input  logic [DW:0]   len,
  input  logic [CW-1:0] fill_data,
  output logic [CW-1:0] out_data
);

  localparam logic [DW-1:0] ONE_D = 1;
  localparam logic [DW:0]   ONE_E = 1;
  localparam logic signed [CW:0] TWO_S = 2;

  logic [CW-1:0] buf_q [MAX_DIM];

  logic [DW:0]   idx_e;
  logic [DW-1:0] lft_i, rgt_i;
  logic [DW:0]   half_e, src_e;
  logic signed [CW:0] cur_x, lft_x, rgt_x, nb_sum;
  logic signed [CW:0] pred_x, upd_x;

  assign idx_e = {1'b0, idx};

  // whole-sample mirror at both ends of the line
  assign lft_i = (idx == '0) ? idx + ONE_D : idx - ONE_D;
  assign rgt_i = ((idx_e + ONE_E) >= len) ? idx - ONE_D : idx + ONE_D;

  assign cur_x  = {buf_q[idx][CW-1], buf_q[idx]};
  assign lft_x  = {buf_q[lft_i][CW-1], buf_q[lft_i]};
  assign rgt_x  = {buf_q[rgt_i][CW-1], buf_q[rgt_i]};
  assign nb_sum = lft_x + rgt_x;

  assign pred_x = cur_x - (nb_sum >>> 1);
  assign upd_x  = cur_x + ((nb_sum + TWO_S) >>> 2);

  always_ff @(posedge clk) begin
    case (op)
      LOP_FILL: buf_q[idx] <= fill_data;
      LOP_PRED: buf_q[idx] <= pred_x[CW-1:0];
      LOP_UPD:  buf_q[idx] <= upd_x[CW-1:0];
      default: ;
    endcase
  end

  // de-interleave on the way out: lows first, highs after
  assign half_e = (len + ONE_E) >> 1;
  assign src_e  = (idx_e < half_e) ? (idx_e << 1)
                                   : (((idx_e - half_e) << 1) + ONE_E);
  assign out_data = buf_q[src_e[DW-1:0]];

endmodule

// File: rtl/dwt2d_ctrl.sv
module dwt2d_ctrl
  import dwt53_pkg::*;
#(
  parameter int MAX_DIM = 16,
  parameter int MAX_LEVELS = 5,
  parameter int IN_W = 12,
  parameter int CW = 23,
  localparam int DW = $clog2(MAX_DIM),
  localparam int LVL_W = $clog2(MAX_LEVELS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [DW:0]     cfg_width,
  input  logic [DW:0]     cfg_height,
  input  logic [LVL_W-1:0] cfg_levels,
  input  logic            cfg_mode,
  input  logic            in_valid,
  input  logic [IN_W-1:0] in_data,
  output logic            in_ready,
  output logic            busy,
  output logic            done,
  output lift_op_e        lop,
  output logic [DW-1:0]   lidx,
  output logic [DW:0]     llen,
  input  logic [CW-1:0]   line_out,
  output logic            mem_we,
  output logic [2*DW-1:0] mem_waddr,
  output logic [CW-1:0]   mem_wdata,
  output logic [2*DW-1:0] eng_addr
);

  localparam logic [DW-1:0]    ONE_D = 1;
  localparam logic [DW-1:0]    TWO_D = 2;
  localparam logic [DW:0]      ONE_E = 1;
  localparam logic [DW:0]      TWO_E = 2;
  localparam logic [LVL_W-1:0] LVL_ONE = 1;
  localparam logic [LVL_W-1:0] LVL_CAP = LVL_W'(MAX_LEVELS);

  eng_state_e      state;
  logic [DW:0]     tw, th, rw, rh;
  logic [LVL_W-1:0] lv_q, lvl;
  logic            byp_q, pass;
  logic [DW-1:0]   lx, ly, line, idx;

  logic [DW:0]   n_cur, n_lines;
  logic          x_last, y_last, idx_last, step_end, line_more;
  logic [DW-1:0] ex, ey;

  // pass 0 walks rows (line = y), pass 1 walks columns (line = x)
  assign n_cur   = pass ? rh : rw;
  assign n_lines = pass ? rw : rh;
  assign ex      = pass ? line : idx;
  assign ey      = pass ? idx : line;
  assign eng_addr = {ey, ex};

  assign x_last    = ({1'b0, lx} + ONE_E) == tw;
  assign y_last    = ({1'b0, ly} + ONE_E) == th;
  assign idx_last  = ({1'b0, idx} + ONE_E) == n_cur;
  assign step_end  = ({1'b0, idx} + TWO_E) >= n_cur;
  assign line_more = ({1'b0, line} + ONE_E) < n_lines;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      tw    <= '0;
      th    <= '0;
      rw    <= '0;
      rh    <= '0;
      lv_q  <= '0;
      lvl   <= '0;
      byp_q <= 1'b0;
      pass  <= 1'b0;
      lx    <= '0;
      ly    <= '0;
      line  <= '0;
      idx   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            tw    <= cfg_width;
            th    <= cfg_height;
            lv_q  <= (cfg_levels > LVL_CAP) ? LVL_CAP : cfg_levels;
            byp_q <= cfg_mode;
            lx    <= '0;
            ly    <= '0;
            state <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (in_valid) begin
            if (x_last) begin
              lx <= '0;
              if (y_last) begin
                rw    <= tw;
                rh    <= th;
                lvl   <= '0;
                pass  <= 1'b0;
                line  <= '0;
                idx   <= '0;
                state <= (byp_q || lv_q == '0) ? ST_DONE : ST_FETCH;
              end else begin
                ly <= ly + ONE_D;
              end
            end else begin
              lx <= lx + ONE_D;
            end
          end
        end
        ST_FETCH: begin
          if (idx_last) begin
            if (n_cur == ONE_E) begin
              idx   <= '0;
              state <= ST_STORE;
            end else begin
              idx   <= ONE_D;
              state <= ST_PRED;
            end
          end else begin
            idx <= idx + ONE_D;
          end
        end
        ST_PRED: begin
          if (step_end) begin
            idx   <= '0;
            state <= ST_UPD;
          end else begin
            idx <= idx + TWO_D;
          end
        end
        ST_UPD: begin
          if (step_end) begin
            idx   <= '0;
            state <= ST_STORE;
          end else begin
            idx <= idx + TWO_D;
          end
        end
        ST_STORE: begin
          if (idx_last) state <= ST_NEXT;
          else idx <= idx + ONE_D;
        end
        ST_NEXT: begin
          idx <= '0;
          if (line_more) begin
            line  <= line + ONE_D;
            state <= ST_FETCH;
          end else if (!pass) begin
            pass  <= 1'b1;
            line  <= '0;
            state <= ST_FETCH;
          end else if ((lvl + LVL_ONE) < lv_q) begin
            lvl   <= lvl + LVL_ONE;
            rw    <= (rw + ONE_E) >> 1;
            rh    <= (rh + ONE_E) >> 1;
            pass  <= 1'b0;
            line  <= '0;
            state <= ST_FETCH;
          end else begin
            state <= ST_DONE;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state)
      ST_FETCH: lop = LOP_FILL;
      ST_PRED:  lop = LOP_PRED;
      ST_UPD:   lop = LOP_UPD;
      default:  lop = LOP_HOLD;
    endcase
  end

  assign lidx = idx;
  assign llen = n_cur;

  assign in_ready  = (state == ST_LOAD);
  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_DONE);
  assign mem_we    = ((state == ST_LOAD) && in_valid) || (state == ST_STORE);
  assign mem_waddr = (state == ST_LOAD) ? {ly, lx} : eng_addr;
  assign mem_wdata = (state == ST_LOAD) ? {{(CW-IN_W){in_data[IN_W-1]}}, in_data}
                                        : line_out;

endmodule

// File: rtl/dwt2d_engine.sv
module dwt2d_engine
  import dwt53_pkg::*;
#(
  parameter int MAX_DIM = 16,
  parameter int IN_W = 12,
  parameter int MAX_LEVELS = 5,
  parameter int COEF_W = IN_W + 2 * MAX_LEVELS + 1,
  localparam int DW = $clog2(MAX_DIM),
  localparam int LVL_W = $clog2(MAX_LEVELS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DW:0]       cfg_width,
  input  logic [DW:0]       cfg_height,
  input  logic [LVL_W-1:0]  cfg_levels,
  input  logic              cfg_mode,
  output logic              busy,
  output logic              done,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [IN_W-1:0]   in_data,
  input  logic [DW-1:0]     rd_x,
  input  logic [DW-1:0]     rd_y,
  output logic [COEF_W-1:0] rd_data
);

  lift_op_e          lop;
  logic [DW-1:0]     lidx;
  logic [DW:0]       llen;
  logic [COEF_W-1:0] line_out, eng_data, mem_wdata;
  logic              mem_we;
  logic [2*DW-1:0]   mem_waddr, eng_addr;

  dwt2d_ctrl #(
    .MAX_DIM(MAX_DIM), .MAX_LEVELS(MAX_LEVELS), .IN_W(IN_W), .CW(COEF_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_width(cfg_width), .cfg_height(cfg_height),
    .cfg_levels(cfg_levels), .cfg_mode(cfg_mode),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .busy(busy), .done(done),
    .lop(lop), .lidx(lidx), .llen(llen), .line_out(line_out),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .eng_addr(eng_addr)
  );

  dwt2d_line_unit #(
    .MAX_DIM(MAX_DIM), .CW(COEF_W)
  ) u_line (
    .clk(clk), .op(lop), .idx(lidx), .len(llen),
    .fill_data(eng_data), .out_data(line_out)
  );

  dwt2d_tile_mem #(
    .AW(2 * DW), .CW(COEF_W)
  ) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .eng_addr(eng_addr), .eng_data(eng_data),
    .rd_addr({rd_y, rd_x}), .rd_data(rd_data)
  );

endmodule

// File: rtl/dwt2d_chk.sv
module dwt2d_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic in_ready
);

  // R2: input is open only inside a tile
  a_r2_ready_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> busy);

  // R3: a load phase opens only after a start seen while idle
  a_r3_load_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> ($past(start) && !$past(busy)));

  // R4: single-cycle completion pulse
  a_r4_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4: busy ends only right after done
  a_r4_busy_ends_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));

  // R4: done is never raised while still loading
  a_r4_no_load_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready);

endmodule

bind dwt2d_engine dwt2d_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start),
  .busy(busy), .done(done), .in_ready(in_ready)
);

// File: tb/dwt2d_engine_tb.sv
module dwt2d_engine_tb;

  localparam int MAXD = 16;
  localparam int IN_W = 12;
  localparam int MAXL = 5;
  localparam int CW   = IN_W + 2 * MAXL + 1;
  localparam int DW   = 4;
  localparam int NV   = 10;

  // width, height, levels, mode, seed (seed 0 = alternating extremes)
  localparam int VEC [NV][5] = '{
    '{16, 16, 3, 0, 1},
    '{ 7,  5, 2, 0, 2},
    '{ 1,  9, 1, 0, 3},
    '{13, 16, 5, 0, 4},
    '{16, 16, 3, 1, 5},
    '{12, 10, 0, 0, 6},
    '{ 3,  3, 7, 0, 7},
    '{16, 16, 5, 0, 0},
    '{ 9,  1, 2, 0, 8},
    '{ 2,  2, 1, 0, 9}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [DW:0] cfg_width = '0, cfg_height = '0;
  logic [2:0]  cfg_levels = '0;
  logic        cfg_mode = 1'b0;
  logic        busy, done, in_ready;
  logic        in_valid = 1'b0;
  logic [IN_W-1:0] in_data = '0;
  logic [DW-1:0] rd_x = '0, rd_y = '0;
  logic [CW-1:0] rd_data;

  int errs = 0;
  int checks = 0;
  int cyc = 0;
  bit finished = 0;

  int src [MAXD][MAXD];
  int mdl [MAXD][MAXD];
  int got [MAXD][MAXD];
  int ln [MAXD];
  int tp [MAXD];

  always #4 clk = ~clk;

  dwt2d_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_width(cfg_width), .cfg_height(cfg_height),
    .cfg_levels(cfg_levels), .cfg_mode(cfg_mode),
    .busy(busy), .done(done),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .rd_x(rd_x), .rd_y(rd_y), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      checks++;
      errs++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  function automatic int pix(int seed, int x, int y);
    int h;
    if (seed == 0) return ((x + y) % 2 == 1) ? 2047 : -2048;
    h = x * 7919 + y * 104729 + seed * 31337;
    h = h ^ (h >>> 7);
    h = h * 97 + 13;
    return ((h % 4096) + 4096) % 4096 - 2048;
  endfunction

  // forward 1-D lifting on ln[0..n-1] with mirrored edges, then split
  task automatic fwd_line(input int n);
    int l, r, hf;
    if (n < 2) return;
    for (int i = 1; i < n; i += 2) begin
      r = (i + 1 < n) ? ln[i+1] : ln[i-1];
      ln[i] = ln[i] - ((ln[i-1] + r) >>> 1);
    end
    for (int i = 0; i < n; i += 2) begin
      l = (i > 0) ? ln[i-1] : ln[i+1];
      r = (i + 1 < n) ? ln[i+1] : ln[i-1];
      ln[i] = ln[i] + ((l + r + 2) >>> 2);
    end
    hf = (n + 1) / 2;
    for (int k = 0; k < n; k++) tp[k] = (k < hf) ? ln[2*k] : ln[2*(k-hf)+1];
    for (int k = 0; k < n; k++) ln[k] = tp[k];
  endtask

  task automatic inv_line(input int n);
    int l, r, hf;
    if (n < 2) return;
    hf = (n + 1) / 2;
    for (int k = 0; k < n; k++) begin
      if (k < hf) tp[2*k] = ln[k];
      else tp[2*(k-hf)+1] = ln[k];
    end
    for (int i = 0; i < n; i += 2) begin
      l = (i > 0) ? tp[i-1] : tp[i+1];
      r = (i + 1 < n) ? tp[i+1] : tp[i-1];
      tp[i] = tp[i] - ((l + r + 2) >>> 2);
    end
    for (int i = 1; i < n; i += 2) begin
      r = (i + 1 < n) ? tp[i+1] : tp[i-1];
      tp[i] = tp[i] + ((tp[i-1] + r) >>> 1);
    end
    for (int k = 0; k < n; k++) ln[k] = tp[k];
  endtask

  task automatic model_fwd(input int w, input int h, input int lv, input int mode);
    int rw, rh;
    for (int y = 0; y < h; y++) for (int x = 0; x < w; x++) mdl[y][x] = src[y][x];
    if (mode == 1) return;
    rw = w; rh = h;
    for (int k = 0; k < lv; k++) begin
      for (int y = 0; y < rh; y++) begin
        for (int x = 0; x < rw; x++) ln[x] = mdl[y][x];
        fwd_line(rw);
        for (int x = 0; x < rw; x++) mdl[y][x] = ln[x];
      end
      for (int x = 0; x < rw; x++) begin
        for (int y = 0; y < rh; y++) ln[y] = mdl[y][x];
        fwd_line(rh);
        for (int y = 0; y < rh; y++) mdl[y][x] = ln[y];
      end
      rw = (rw + 1) / 2; rh = (rh + 1) / 2;
    end
  endtask

  // undo the transform in got[][] in reverse order
  task automatic model_inv(input int w, input int h, input int lv);
    int rws [MAXL];
    int rhs [MAXL];
    rws[0] = w; rhs[0] = h;
    for (int k = 1; k < lv; k++) begin
      rws[k] = (rws[k-1] + 1) / 2; rhs[k] = (rhs[k-1] + 1) / 2;
    end
    for (int k = lv - 1; k >= 0; k--) begin
      for (int x = 0; x < rws[k]; x++) begin
        for (int y = 0; y < rhs[k]; y++) ln[y] = got[y][x];
        inv_line(rhs[k]);
        for (int y = 0; y < rhs[k]; y++) got[y][x] = ln[y];
      end
      for (int y = 0; y < rhs[k]; y++) begin
        for (int x = 0; x < rws[k]; x++) ln[x] = got[y][x];
        inv_line(rws[k]);
        for (int x = 0; x < rws[k]; x++) got[y][x] = ln[x];
      end
    end
  endtask

  task automatic run_tile(input int w, input int h, input int lv, input int mode,
                          input int seed, input bit gaps, input bit junk,
                          input bit restart);
    int n, wait_c, bad, bx, by, elv;
    string tag;
    for (int y = 0; y < h; y++) for (int x = 0; x < w; x++) src[y][x] = pix(seed, x, y);
    elv = (lv > MAXL) ? MAXL : lv;
    model_fwd(w, h, elv, mode);

    @(negedge clk);
    if (junk) begin
      // R2: samples offered while idle must be dropped
      for (int j = 0; j < 5; j++) begin
        in_valid = 1'b1; in_data = 12'h5A5;
        @(negedge clk);
        chk(in_ready == 1'b0, "R2", "ready low while idle", in_ready, 0);
      end
      in_valid = 1'b0;
    end
    cfg_width = (DW+1)'(w); cfg_height = (DW+1)'(h);
    cfg_levels = 3'(lv); cfg_mode = mode[0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1 && in_ready == 1'b1, "R2", "load opens after start",
        {busy, in_ready}, 3);

    n = 0;
    while (n < w * h) begin
      if (gaps && (n % 3 == 1) && !in_valid) begin
        in_valid = 1'b0;
        in_data = 12'hFFF;
        @(negedge clk);
        in_valid = 1'b1;
        continue;
      end
      in_valid = 1'b1;
      in_data = src[n / w][n % w][IN_W-1:0];
      if (in_ready) n++;
      @(negedge clk);
      if (gaps) in_valid = 1'b0;
    end
    in_valid = 1'b0;

    wait_c = 0;
    while (!done && wait_c < 20000) begin
      if (restart && wait_c == 3) begin
        start = 1'b1; cfg_mode = 1'b1; cfg_width = 1; cfg_height = 1;
      end else start = 1'b0;
      @(negedge clk);
      wait_c++;
    end
    start = 1'b0;
    chk(done == 1'b1, "R4", "done seen", done, 1);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R4", "done one cycle then idle",
        {done, busy}, 0);
    if (restart)
      chk(in_ready == 1'b0, "R3", "no load reopened after busy start", in_ready, 0);

    for (int y = 0; y < h; y++) for (int x = 0; x < w; x++) begin
      rd_x = DW'(x); rd_y = DW'(y);
      @(negedge clk);
      got[y][x] = int'($signed(rd_data));
    end

    bad = 0; bx = 0; by = 0;
    for (int y = 0; y < h; y++) for (int x = 0; x < w; x++)
      if (got[y][x] != mdl[y][x] && bad == 0) begin bad = 1; bx = x; by = y; end
    if (mode == 1 || lv == 0) tag = "R5";
    else if (lv > MAXL) tag = "R10";
    else tag = "R6 R7 R8 R9";
    if (restart) tag = {tag, " R3"};
    if (gaps || junk) tag = {tag, " R2"};
    chk(bad == 0, tag, $sformatf("tile %0dx%0d L%0d coef(%0d,%0d)", w, h, lv, bx, by),
        got[by][bx], mdl[by][bx]);

    if (mode == 0 && elv > 0) begin
      model_inv(w, h, elv);
      bad = 0; bx = 0; by = 0;
      for (int y = 0; y < h; y++) for (int x = 0; x < w; x++)
        if (got[y][x] != src[y][x] && bad == 0) begin bad = 1; bx = x; by = y; end
      chk(bad == 0, "R12", $sformatf("inverse %0dx%0d (%0d,%0d)", w, h, bx, by),
          got[by][bx], src[by][bx]);
    end
  endtask

  initial begin
    int a, b;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy == 1'b0 && done == 1'b0 && in_ready == 1'b0, "R1", "reset outputs",
        {busy, done, in_ready}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && in_ready == 1'b0, "R1", "idle after reset", {busy, in_ready}, 0);

    for (int v = 0; v < NV; v++)
      run_tile(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], 0, 0, 0);

    // directed: gaps in valid, junk before start, start while busy
    run_tile(11, 7, 2, 0, 21, 1, 1, 0);
    run_tile(16, 13, 3, 0, 22, 0, 0, 1);

    // R11: read latency of one cycle
    rd_x = 0; rd_y = 0;
    @(negedge clk);
    a = int'($signed(rd_data));
    rd_x = 1; rd_y = 0;
    #1;
    chk(int'($signed(rd_data)) == a, "R11", "no change before edge",
        int'($signed(rd_data)), a);
    @(negedge clk);
    b = int'($signed(rd_data));
    chk(b == mdl[0][1], "R11", "new address after one edge", b, mdl[0][1]);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule